// File: doc/BRIEF.md
# APB Word-Store Completer

This block is an APB completer with a small word-addressed store. A requester on the bus writes 32-bit words into it and reads them back. Every transfer completes in the minimum two cycles, so there are no wait states. The block has no error response and no byte strobes.

A transfer is decoded in its setup cycle, when select is high and enable is low. A write commits in the following access cycle, using the address and data present in that cycle. A read looks up the store at the end of the setup cycle, so the word is already on the read-data port for the whole access cycle.

Each entry carries its own valid flag:

- A location that has not been written since reset reads as zero.
- Reset wipes the store by clearing all the flags in one cycle.
- Outside the access cycle of a read, the read-data port is held at zero.

Top module: `apb_word_responder`

## Requirements
- R1: A transfer starts only in a setup cycle (psel=1, penable=0). A cycle that looks like an access cycle (psel=1, penable=1, or penable=1 with psel=0) but has no setup cycle before it stores nothing and returns nothing.
- R2: For a write (pwrite=1 in setup), the word on pwdata in the access cycle is stored at the entry addressed by paddr in that access cycle.
- R3: For a read (pwrite=0 in setup), prdata carries the stored word for the whole access cycle, and only in that cycle may it be nonzero.
- R4: A read of an entry never written since the last reset returns 0.
- R5: prdata is 0 in idle cycles, in setup cycles, and in the access cycle of a write.
- R6: With rst high (synchronous, active high), prdata is 0 from the next clock edge on, and every entry becomes unwritten.
- R7: With default parameters the entry is selected by paddr[7:2]. Bits [1:0] and [31:8] are ignored, so 0x104 and 0x004 name the same entry.
- R8: A read set up in the cycle right after a write's access cycle, to the same entry, returns the newly written word.
- R9: A later write to an entry replaces the earlier word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access-cycle marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, zero outside a read access |

## Verification
The bench builds the block with its defaults: 32-bit address and data and 64 entries. With these values the lowest and highest entries (0x00 and 0xFC) are both reachable, and an address with bit 8 set aliases onto entry 1, which exercises the ignored upper bits. Back-to-back write-then-read on one entry, overwrites, access cycles with no setup cycle before them, and a reset in the middle of a run are each driven. The data patterns are distinct so that a mixed-up entry shows up as a wrong word.

// File: rtl/apb_resp_pkg.sv
package apb_resp_pkg;
  // What the next cycle is expected to be, decided in a setup cycle
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WR   = 2'd1,
    PH_RD   = 2'd2
  } apb_phase_e;
endpackage

// File: rtl/apb_resp_decode.sv
module apb_resp_decode
  import apb_resp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic              rd_setup,
  output logic              wr_commit,
  output logic [IDX_W-1:0]  idx
);
  apb_phase_e phase_q;
  logic       setup;

  assign setup     = psel && !penable;
  assign rd_setup  = setup && !pwrite;
  assign wr_commit = (phase_q == PH_WR) && psel && penable;
  assign idx       = paddr[IDX_W+1:2];

  always_ff @(posedge clk) begin
    if (rst)
      phase_q <= PH_IDLE;
    else if (setup)
      phase_q <= pwrite ? PH_WR : PH_RD;
    else
      phase_q <= PH_IDLE;
  end
endmodule

// File: rtl/apb_resp_ram.sv
module apb_resp_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // No reset on the array so that a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/apb_resp_valid.sv
module apb_resp_valid #(
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             look_en,
  input  logic [IDX_W-1:0] look_idx,
  output logic             hit_q
);
  logic [DEPTH-1:0] flag_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flag_q[g] <= 1'b0;
      else if (set_en && (set_idx == IDX_W'(g)))
        flag_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      hit_q <= 1'b0;
    else
      hit_q <= look_en && flag_q[look_idx];
  end
endmodule

// File: rtl/apb_word_responder.sv
module apb_word_responder #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata
);
  localparam int IDX_W = $clog2(DEPTH);

  logic              rd_setup;
  logic              wr_commit;
  logic [IDX_W-1:0]  idx;
  logic              hit_q;
  logic [DATA_W-1:0] ram_q;

  apb_resp_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dec (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .rd_setup(rd_setup), .wr_commit(wr_commit), .idx(idx)
  );

  apb_resp_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_commit), .waddr(idx), .wdata(pwdata),
    .raddr(idx), .rdata(ram_q)
  );

  apb_resp_valid #(.DEPTH(DEPTH)) u_vld (
    .clk(clk), .rst(rst), .set_en(wr_commit), .set_idx(idx),
    .look_en(rd_setup), .look_idx(idx), .hit_q(hit_q)
  );

  // Both terms are registers, so prdata is zero unless a valid read hit
  assign prdata = hit_q ? ram_q : '0;
endmodule

// File: rtl/apb_word_responder_chk.sv
module apb_word_responder_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata
);
  localparam int IDX_W = $clog2(DEPTH);

  logic rd_pend;
  always_ff @(posedge clk) begin
    if (rst) rd_pend <= 1'b0;
    else     rd_pend <= psel && !penable && !pwrite;
  end

  // R5: no read was set up in the previous cycle, so prdata must be zero
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_pend |-> prdata == '0);

  // R3: nonzero read data only in the access cycle of a read
  p_data_in_access_r3: assert property (@(posedge clk) disable iff (rst)
    prdata != '0 |-> (psel && penable && !pwrite));

  // R6: reset forces prdata to zero from the next edge
  p_reset_clear_r6: assert property (@(posedge clk)
    rst |=> prdata == '0);

  // R8: a read right after a write to the same entry returns the new word
  p_rd_after_wr_r8: assert property (@(posedge clk) disable iff (rst)
    (psel && !penable && !pwrite && $past(psel && penable && pwrite)
     && paddr[IDX_W+1:2] == $past(paddr[IDX_W+1:2]) && !$past(rst))
    |=> prdata == $past(pwdata, 2));
endmodule

bind apb_word_responder apb_word_responder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata)
);

// File: tb/tb_apb_word_responder.sv
module tb_apb_word_responder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [31:0] paddr = '0, pwdata = '0;
  logic [31:0] prdata;
  int          n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  apb_word_responder dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: prdata=%h expected=%h", req, got, exp);
    end
  endtask

  // All drives happen at the falling edge
  task automatic idle();
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; pwdata = '0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    #1 check("R5 write access", prdata, 32'h0);
  endtask

  task automatic rd(input string req, input logic [31:0] a, input logic [31:0] exp);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    #1 check("R5 read setup", prdata, 32'h0);
    @(negedge clk);
    penable = 1;
    #1 check(req, prdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; psel = 0; penable = 0;
    repeat (2) @(negedge clk);
    check("R6 reset prdata", prdata, 32'h0);
    rst = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    idle();
    #1 check("R5 idle", prdata, 32'h0);
  endtask

  task automatic t_unwritten();
    rd("R4 unwritten 0x00", 32'h00, 32'h0);
    rd("R4 unwritten 0xFC", 32'hFC, 32'h0);
    idle();
  endtask

  task automatic t_basic();
    wr(32'h00, 32'hA5A5_0001);
    wr(32'hFC, 32'h5A5A_003F);
    wr(32'h40, 32'hFFFF_FFFF);
    idle();
    #1 check("R5 idle after writes", prdata, 32'h0);
    rd("R2 R3 entry 0", 32'h00, 32'hA5A5_0001);
    rd("R2 R3 entry 63", 32'hFC, 32'h5A5A_003F);
    rd("R3 entry 16", 32'h40, 32'hFFFF_FFFF);
    idle();
    #1 check("R3 zero after access", prdata, 32'h0);
  endtask

  task automatic t_alias();
    wr(32'h0000_0104, 32'h1234_5678);
    idle();
    rd("R7 alias 0x004", 32'h0000_0004, 32'h1234_5678);
    rd("R7 low bits 0x007", 32'h8000_0007, 32'h1234_5678);
    idle();
  endtask

  task automatic t_b2b();
    wr(32'h20, 32'hCAFE_0008);
    rd("R8 back-to-back", 32'h20, 32'hCAFE_0008);
    wr(32'h20, 32'hBEEF_0009);
    rd("R9 overwrite", 32'h20, 32'hBEEF_0009);
    idle();
  endtask

  task automatic t_no_setup();
    @(negedge clk);
    psel = 1; penable = 1; pwrite = 1; paddr = 32'h30; pwdata = 32'hDEAD_0001;
    @(negedge clk);
    psel = 0; penable = 1; pwrite = 1; paddr = 32'h34; pwdata = 32'hDEAD_0002;
    @(negedge clk);
    psel = 1; penable = 1; pwrite = 0; paddr = 32'h00;
    #1 check("R1 no read without setup", prdata, 32'h0);
    idle();
    rd("R1 stray access 0x30", 32'h30, 32'h0);
    rd("R1 stray access 0x34", 32'h34, 32'h0);
    idle();
  endtask

  task automatic t_reset_wipe();
    wr(32'h08, 32'h0BAD_F00D);
    idle();
    do_reset();
    rd("R6 wiped entry", 32'h08, 32'h0);
    rd("R6 wiped entry 0", 32'h00, 32'h0);
    idle();
  endtask

  initial begin
    t_reset_state();
    t_unwritten();
    t_basic();
    t_alias();
    t_b2b();
    t_no_setup();
    t_reset_wipe();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: prdata=%h expected=done", prdata);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule